// File: doc/BRIEF.md
# Dual-Clock FIFO with Shared Status Flags

This block is a first-in first-out buffer over a fixed 4096-bit storage array. The word width is a parameter of 1, 2, 4 or 8 bits, which sets the depth to 4096, 2048, 1024 or 512 words. A producer pushes words through a write port that has its own clock and enable. A consumer pulls words through a read port that has its own clock and enable. The two clocks may be the same net or may be unrelated.

Status is compressed into a few outputs. One active-low line signals "empty or full", and a companion bit tells the two cases apart. A half-full line is also provided. One programmable line signals "nearly empty or nearly full", with the two margins taken from input ports. An optional extra register stage on the read data trades one cycle of latency for a cleaner output path.

Top module: `dcfifo_flags`

## Requirements
- R1: A word is stored on a rising `wclk` edge when `we` is high and the FIFO is not full. Words leave in the order they were written.
- R2: A read happens on a rising `rclk` edge when `re` is high and the FIFO is not empty. The word appears on `rdata` one `rclk` edge later, or two edges later when `REG_OUT` is 1.
- R3: A write attempted while full is ignored. The occupancy and the stored words do not change.
- R4: A read attempted while empty is ignored. `rdata` keeps its previous value.
- R5: `ef_n` is 0 when the FIFO is empty or full, and 1 otherwise. When `ef_n` is 0, `ef_full` is 1 for full and 0 for empty. `ef_full` is 0 whenever the FIFO is not full.
- R6: `hf` is 1 when the occupancy is at least DEPTH/2, and 0 otherwise.
- R7: `paf` is 1 when the occupancy is at most `ae_lvl`, or when the occupancy plus `af_lvl` is at least DEPTH. Otherwise it is 0.
- R8: After reset the FIFO is empty: `ef_n`=0, `ef_full`=0, `hf`=0 and `paf`=1.
- R9: With unrelated write and read clocks, every word written is read back intact and in order. Each pointer crosses to the other domain with at most one bit changing per step.
- R10: The depth is 4096/W words. With W=8, the 512th write without reads makes the FIFO full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| we | input | 1 | Write enable |
| wdata | input | W | Word to store |
| rclk | input | 1 | Read clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| re | input | 1 | Read enable |
| rdata | output | W | Word read out |
| ae_lvl | input | AW+1 | Nearly-empty margin in words |
| af_lvl | input | AW+1 | Nearly-full margin in words |
| ef_n | output | 1 | Low when empty or full |
| ef_full | output | 1 | High when full; tells full from empty while `ef_n` is low |
| hf | output | 1 | Occupancy at least half the depth |
| paf | output | 1 | Nearly empty or nearly full |

## Verification
The checks assume that both resets are held together for several cycles of each clock, and that `ae_lvl` and `af_lvl` stay constant while traffic flows. They also assume `af_lvl` does not exceed the depth. The stimulus asserts both resets at once for several cycles, and changes the margins only while the FIFO is idle. In the phase with unrelated clocks, the reader issues a read only once the read side reports data. This keeps the read side's own view of the pointers in control of every read.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    localparam int unsigned ARRAY_BITS = 4096;
    localparam int unsigned PTR_MAX    = 13;

    typedef logic [PTR_MAX-1:0] ptr_t;

    typedef struct packed {
        logic full;
        logic half;
        logic alm_full;
    } wflags_t;

    typedef struct packed {
        logic empty;
        logic alm_empty;
    } rflags_t;

    function automatic ptr_t bin2gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(ptr_t g);
        ptr_t b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcfifo_ptr_sync.sv
module dcfifo_ptr_sync #(
    parameter int unsigned PW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] d,
    output logic [PW-1:0] q
);
    logic [PW-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcfifo_wr_ctrl.sv
module dcfifo_wr_ctrl
    import dcfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned PW    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PW-1:0]     rgray_s,
    input  logic [PW-1:0]     af_lvl,
    output logic [PW-1:0]     wbin,
    output logic [PW-1:0]     wgray,
    output logic              wr_ok,
    output wflags_t           flags
);
    logic [PW-1:0] rbin_s, wbin_n, wgray_n, occ_n;
    logic [PW:0]   alm_sum;
    ptr_t          conv_r, conv_w;

    always_comb begin
        conv_r  = gray2bin(PTR_MAX'(rgray_s));
        rbin_s  = conv_r[PW-1:0];
        wr_ok   = we & ~flags.full;
        wbin_n  = wbin + PW'(wr_ok);
        conv_w  = bin2gray(PTR_MAX'(wbin_n));
        wgray_n = conv_w[PW-1:0];
        occ_n   = wbin_n - rbin_s;
        alm_sum = {1'b0, occ_n} + {1'b0, af_lvl};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
            flags <= '0;
        end else begin
            wbin           <= wbin_n;
            wgray          <= wgray_n;
            flags.full     <= (occ_n == PW'(DEPTH));
            flags.half     <= (occ_n >= PW'(DEPTH / 2));
            flags.alm_full <= (alm_sum >= (PW+1)'(DEPTH));
        end
    end
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
module dcfifo_rd_ctrl
    import dcfifo_pkg::*;
#(
    parameter int unsigned PW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              re,
    input  logic [PW-1:0]     wgray_s,
    input  logic [PW-1:0]     ae_lvl,
    output logic [PW-1:0]     rbin,
    output logic [PW-1:0]     rgray,
    output logic              rd_ok,
    output rflags_t           flags
);
    logic [PW-1:0] wbin_s, rbin_n, rgray_n, occ_n;
    ptr_t          conv_w, conv_r;

    always_comb begin
        conv_w  = gray2bin(PTR_MAX'(wgray_s));
        wbin_s  = conv_w[PW-1:0];
        rd_ok   = re & ~flags.empty;
        rbin_n  = rbin + PW'(rd_ok);
        conv_r  = bin2gray(PTR_MAX'(rbin_n));
        rgray_n = conv_r[PW-1:0];
        occ_n   = wbin_s - rbin_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin            <= '0;
            rgray           <= '0;
            flags.empty     <= 1'b1;
            flags.alm_empty <= 1'b1;
        end else begin
            rbin            <= rbin_n;
            rgray           <= rgray_n;
            flags.empty     <= (occ_n == '0);
            flags.alm_empty <= (occ_n <= ae_lvl);
        end
    end
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags
    import dcfifo_pkg::*;
#(
    parameter int unsigned W       = 8,
    parameter bit          REG_OUT = 1'b1,
    localparam int unsigned DEPTH  = ARRAY_BITS / W,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned PW     = AW + 1
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          re,
    output logic [W-1:0]  rdata,
    input  logic [PW-1:0] ae_lvl,
    input  logic [PW-1:0] af_lvl,
    output logic          ef_n,
    output logic          ef_full,
    output logic          hf,
    output logic          paf
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] rgray_w, wgray_r;
    logic          wr_ok, rd_ok;
    wflags_t       wf;
    rflags_t       rf;
    logic [W-1:0]  rd_word;

    dcfifo_ptr_sync #(.PW(PW)) u_r2w (
        .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w)
    );

    dcfifo_ptr_sync #(.PW(PW)) u_w2r (
        .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r)
    );

    dcfifo_wr_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_wr (
        .clk(wclk), .rst(wrst), .we(we), .rgray_s(rgray_w), .af_lvl(af_lvl),
        .wbin(wbin), .wgray(wgray), .wr_ok(wr_ok), .flags(wf)
    );

    dcfifo_rd_ctrl #(.PW(PW)) u_rd (
        .clk(rclk), .rst(rrst), .re(re), .wgray_s(wgray_r), .ae_lvl(ae_lvl),
        .rbin(rbin), .rgray(rgray), .rd_ok(rd_ok), .flags(rf)
    );

    always_ff @(posedge wclk) begin
        if (wr_ok) begin
            mem[wbin[AW-1:0]] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rd_word <= '0;
        end else if (rd_ok) begin
            rd_word <= mem[rbin[AW-1:0]];
        end
    end

    generate
        if (REG_OUT) begin : g_oreg
            logic [W-1:0] out_q;
            always_ff @(posedge rclk) begin
                if (rrst) begin
                    out_q <= '0;
                end else begin
                    out_q <= rd_word;
                end
            end
            assign rdata = out_q;
        end else begin : g_direct
            assign rdata = rd_word;
        end
    endgenerate

    assign ef_n    = ~(wf.full | rf.empty);
    assign ef_full = wf.full;
    assign hf      = wf.half;
    assign paf     = wf.alm_full | rf.alm_empty;

endmodule

// File: rtl/dcfifo_flags_chk.sv
module dcfifo_flags_chk
    import dcfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned PW    = 10
) (
    input logic          wclk,
    input logic          wrst,
    input logic          rclk,
    input logic          rrst,
    input logic          we,
    input logic          re,
    input logic [PW-1:0] wbin,
    input logic [PW-1:0] rbin,
    input logic [PW-1:0] wgray,
    input logic [PW-1:0] rgray,
    input logic [PW-1:0] rgray_w,
    input logic          wfull,
    input logic          rempty
);
    ptr_t          rconv;
    logic [PW-1:0] wocc;

    always_comb begin
        rconv = gray2bin(PTR_MAX'(rgray_w));
        wocc  = wbin - rconv[PW-1:0];
    end

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (wrst)
        wocc <= PW'(DEPTH)); // R3

    AST_FULL_WRITE_HELD: assert property (@(posedge wclk) disable iff (wrst)
        (wfull && we) |=> $stable(wbin)); // R3

    AST_EMPTY_READ_HELD: assert property (@(posedge rclk) disable iff (rrst)
        (rempty && re) |=> $stable(rbin)); // R4

    AST_WGRAY_ONE_STEP: assert property (@(posedge wclk) disable iff (wrst)
        $countones(wgray ^ $past(wgray)) <= 1); // R9

    AST_RGRAY_ONE_STEP: assert property (@(posedge rclk) disable iff (rrst)
        $countones(rgray ^ $past(rgray)) <= 1); // R9

endmodule

bind dcfifo_flags dcfifo_flags_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
    .wclk(wclk), .wrst(wrst), .rclk(rclk), .rrst(rrst),
    .we(we), .re(re), .wbin(wbin), .rbin(rbin),
    .wgray(wgray), .rgray(rgray), .rgray_w(rgray_w),
    .wfull(wf.full), .rempty(rf.empty)
);

// File: tb/dcfifo_flags_tb.sv
`timescale 1ns/1ps
module dcfifo_flags_tb;
    localparam int W     = 8;
    localparam int DEPTH = 512;
    localparam int PW    = 10;
    localparam bit OREG  = 1'b1;
    localparam int LAT   = OREG ? 2 : 1;

    typedef struct packed {
        logic [9:0] nwr;
        logic [9:0] nrd;
        logic       efn;
        logic       efull;
        logic       hf;
        logic       paf;
    } vec_t;

    // occupancy after each row: 1,21,256,255,496,512,512,12,0,0 (margins 16/16)
    localparam vec_t VT [10] = '{
        '{10'd1,   10'd0,   1'b1, 1'b0, 1'b0, 1'b1},
        '{10'd20,  10'd0,   1'b1, 1'b0, 1'b0, 1'b0},
        '{10'd235, 10'd0,   1'b1, 1'b0, 1'b1, 1'b0},
        '{10'd0,   10'd1,   1'b1, 1'b0, 1'b0, 1'b0},
        '{10'd241, 10'd0,   1'b1, 1'b0, 1'b1, 1'b1},
        '{10'd16,  10'd0,   1'b0, 1'b1, 1'b1, 1'b1},
        '{10'd3,   10'd0,   1'b0, 1'b1, 1'b1, 1'b1},
        '{10'd0,   10'd500, 1'b1, 1'b0, 1'b0, 1'b1},
        '{10'd0,   10'd12,  1'b0, 1'b0, 1'b0, 1'b1},
        '{10'd0,   10'd2,   1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic clk = 1'b0, aclk = 1'b0, async_mode = 1'b0;
    logic rst = 1'b1, we = 1'b0, re = 1'b0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic [PW-1:0] ae_lvl = 10'd16, af_lvl = 10'd16;
    logic ef_n, ef_full, hf, paf;
    logic wclk, rclk;

    always #2   clk  = ~clk;
    always #3.5 aclk = ~aclk;
    assign wclk = clk;
    assign rclk = async_mode ? aclk : clk;

    dcfifo_flags #(.W(W), .REG_OUT(OREG)) u_dut (
        .wclk(wclk), .wrst(rst), .we(we), .wdata(wdata),
        .rclk(rclk), .rrst(rst), .re(re), .rdata(rdata),
        .ae_lvl(ae_lvl), .af_lvl(af_lvl),
        .ef_n(ef_n), .ef_full(ef_full), .hf(hf), .paf(paf)
    );

    int total = 0, bad = 0;
    logic [7:0] mq [0:1023];
    int mh = 0, mt = 0, wseq = 0;
    logic [7:0] last_rd = '0;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (10) @(negedge wclk);
        repeat (10) @(negedge rclk);
    endtask

    task automatic wr_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            we    = 1'b1;
            wdata = 8'(wseq * 29 + 3);
            wseq++;
            if (mt - mh < DEPTH) begin
                mq[mt % 1024] = wdata;
                mt++;
            end
        end
        @(negedge wclk);
        we = 1'b0;
    endtask

    task automatic rd_one(input string req);
        logic [7:0] exp;
        logic       valid;
        valid = (mt - mh) > 0;
        @(negedge rclk);
        re = 1'b1;
        @(posedge rclk);
        @(negedge rclk);
        re = 1'b0;
        for (int k = 1; k < LAT; k++) begin
            @(posedge rclk);
            @(negedge rclk);
        end
        if (valid) begin
            exp = mq[mh % 1024];
            mh++;
        end else begin
            exp = last_rd;
        end
        check(req, int'(rdata), int'(exp));
        last_rd = exp;
    endtask

    task automatic reset_all();
        @(negedge wclk);
        rst = 1'b1;
        repeat (6) @(negedge wclk);
        repeat (6) @(negedge rclk);
        @(negedge wclk);
        rst = 1'b0;
        mh = 0; mt = 0; last_rd = '0;
        settle();
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        reset_all();
        // R8 reset state
        check("R8 ef_n", ef_n, 0);
        check("R8 ef_full", ef_full, 0);
        check("R8 hf", hf, 0);
        check("R8 paf", paf, 1);

        // Table: R1 R2 R3 R4 R5 R6 R7 R10
        for (int v = 0; v < 10; v++) begin
            if (VT[v].nwr != 0) wr_burst(int'(VT[v].nwr));
            for (int k = 0; k < int'(VT[v].nrd); k++) rd_one("R1/R2/R4 data");
            settle();
            check("R5 ef_n", ef_n, VT[v].efn);
            check("R5/R10 ef_full", ef_full, VT[v].efull);
            check("R6 hf", hf, VT[v].hf);
            check("R7 paf", paf, VT[v].paf);
        end

        // R3: words written after full were dropped; stored words intact
        wr_burst(4);
        settle();
        check("R3 count via hf", hf, 0);
        for (int k = 0; k < 4; k++) rd_one("R3 data after full");
        settle();
        check("R5 empty again", ef_n, 0);

        // R8: reset while holding data
        wr_burst(300);
        settle();
        check("R6 hf before reset", hf, 1);
        reset_all();
        check("R8 ef_n after reset", ef_n, 0);
        check("R8 hf after reset", hf, 0);
        check("R8 ef_full after reset", ef_full, 0);

        // R7: margins from ports
        ae_lvl = 10'd0;
        settle();
        check("R7 paf occ0 ae0", paf, 1);
        wr_burst(1);
        settle();
        check("R7 paf occ1 ae0", paf, 0);
        af_lvl = 10'd511;
        settle();
        check("R7 paf occ1 af511", paf, 1);
        rd_one("R2 single");
        ae_lvl = 10'd16;
        af_lvl = 10'd16;
        settle();

        // R9: unrelated clocks
        async_mode = 1'b1;
        reset_all();
        fork
            begin
                for (int i = 0; i < 60; i++) begin
                    wr_burst(1);
                    if (i % 3 == 0) repeat (2) @(negedge wclk);
                end
            end
            begin
                for (int i = 0; i < 60; i++) begin
                    do @(negedge rclk); while (ef_n !== 1'b1);
                    rd_one("R9 async data");
                end
            end
        join
        settle();
        check("R9 empty at end", ef_n, 0);
        check("R9 ef_full at end", ef_full, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule